// File: doc/BRIEF.md
# Hardware Repeat-Block Program Counter Sequencer

This block decides the program counter for the next instruction word. When a word finishes executing, the core raises `word_done` together with the PC it held before the word (`pc_before`) and the PC the word left behind (`pc_after`), which differs from `pc_before` when the word branched. One cycle later the block presents `next_pc`. The PC counts words, so one increment moves 32 bits (4 bytes) of code.

Loops run without a branch instruction. A configuration write through `cfg_load` stores a loop-start address, a loop-end address and an iteration count, and arms the loop. After every word, if the loop is armed and `pc_after` equals the loop-end address, the count drops by one. While the decremented count is nonzero, the PC jumps back to the loop start. When it reaches zero, the loop disarms and execution falls through. After this check, a PC that still equals `pc_before` steps forward by one word.

All pins are plain control and data. `word_done` is a single-cycle qualifier with no back-pressure: the block accepts every strobe, and its result is always ready one cycle later.

Top module: `rpt_pc_ctrl`

## Requirements
- R1: A synchronous reset sets `next_pc` to `reset_vec`, clears `rpt_active`, and clears the stored count and addresses.
- R2: `next_pc` changes only on the clock edge that samples `word_done` high (apart from reset); in every other cycle it holds its value.
- R3: A cycle with `cfg_load` high stores `cfg_start`, `cfg_end` and `cfg_count`. From the next cycle, `rpt_active` is 1 if `cfg_count` is nonzero and 0 if it is zero.
- R4: For a word where the loop does not fire (`rpt_active` low, or `pc_after` differs from the stored end) and `pc_after` differs from `pc_before`, `next_pc` equals `pc_after`.
- R5: When the PC from the repeat stage equals `pc_before`, `next_pc` is that value plus 1, wrapping modulo 2^PC_W (for example 0xFFFF becomes 0x0000).
- R6: When the loop fires with a stored count above 1, the count drops by one, `rpt_active` stays 1, and the loop-start address goes on to the R5 step. It therefore becomes `next_pc` unless it equals `pc_before`, in which case `next_pc` is start+1.
- R7: When the loop fires with a stored count of 1, the count becomes 0 and `rpt_active` clears. The PC falls through to `pc_after`, which then goes on to the R5 step.
- R8: While `rpt_active` is low, a `pc_after` equal to the stored end address has no effect on `next_pc`.
- R9: When `cfg_load` and `word_done` are high in the same cycle, the word is resolved with the previously stored loop state, and the loaded values replace that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | PC_W | PC value loaded by reset |
| cfg_load | input | 1 | Write strobe for the loop registers |
| cfg_start | input | PC_W | Loop-start word address |
| cfg_end | input | PC_W | Loop-end word address |
| cfg_count | input | CNT_W | Iteration count (0 leaves the loop disarmed) |
| word_done | input | 1 | Instruction word completed this cycle |
| pc_before | input | PC_W | PC before the word executed |
| pc_after | input | PC_W | PC after the word executed |
| next_pc | output | PC_W | Registered PC for the next word |
| rpt_active | output | 1 | Loop armed flag |

## Verification
The assertions assume that `word_done` is a one-cycle strobe, with `pc_before` and `pc_after` stable and meaningful in that cycle. They also assume that `cfg_load` carries a consistent address pair. Some properties, such as those for the firing loop, only hold when no configuration write lands in the same cycle, so they exclude `cfg_load` in their antecedents. The stimulus drives every input at the falling edge, holds each strobe for exactly one cycle, and keeps loads apart from words except in the single directed case that exercises R9.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  // Outcome of the repeat stage for one completed word
  typedef enum logic [1:0] {
    RPT_NONE = 2'd0,  // loop did not fire
    RPT_LOOP = 2'd1,  // jump back to the loop start
    RPT_EXIT = 2'd2   // last iteration, fall through
  } rpt_act_e;
endpackage

// File: rtl/rpt_regs.sv
module rpt_regs
  import rpt_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [PC_W-1:0]  cfg_start,
  input  logic [PC_W-1:0]  cfg_end,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             word_done,
  input  rpt_act_e         act,
  input  logic [CNT_W-1:0] cnt_dec,
  output logic [PC_W-1:0]  start_q,
  output logic [PC_W-1:0]  end_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             active_q
);
  // Reset first, then a configuration write, then the loop bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      end_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (cfg_load) begin
      start_q  <= cfg_start;
      end_q    <= cfg_end;
      cnt_q    <= cfg_count;
      active_q <= (cfg_count != '0);
    end else if (word_done && (act != RPT_NONE)) begin
      cnt_q <= cnt_dec;
      if (act == RPT_EXIT) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rpt_match.sv
module rpt_match
  import rpt_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             active_q,
  input  logic [PC_W-1:0]  start_q,
  input  logic [PC_W-1:0]  end_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [PC_W-1:0]  pc_after,
  output rpt_act_e         act,
  output logic [CNT_W-1:0] cnt_dec,
  output logic [PC_W-1:0]  pc_mid
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_end;

  always_comb begin
    at_end  = active_q && (pc_after == end_q);
    cnt_dec = cnt_q - ONE;
    act     = RPT_NONE;
    if (at_end) act = (cnt_dec == '0) ? RPT_EXIT : RPT_LOOP;
    pc_mid  = (act == RPT_LOOP) ? start_q : pc_after;
  end
endmodule

// File: rtl/pc_step.sv
module pc_step #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] reset_vec,
  input  logic            word_done,
  input  logic [PC_W-1:0] pc_before,
  input  logic [PC_W-1:0] pc_mid,
  output logic [PC_W-1:0] next_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1);

  logic [PC_W-1:0] pc_fin;

  // An unchanged PC advances by one word
  always_comb pc_fin = (pc_mid == pc_before) ? pc_mid + STEP : pc_mid;

  always_ff @(posedge clk) begin
    if (rst)            next_pc <= reset_vec;
    else if (word_done) next_pc <= pc_fin;
  end
endmodule

// File: rtl/rpt_pc_ctrl.sv
module rpt_pc_ctrl
  import rpt_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  reset_vec,
  input  logic             cfg_load,
  input  logic [PC_W-1:0]  cfg_start,
  input  logic [PC_W-1:0]  cfg_end,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             word_done,
  input  logic [PC_W-1:0]  pc_before,
  input  logic [PC_W-1:0]  pc_after,
  output logic [PC_W-1:0]  next_pc,
  output logic             rpt_active
);
  logic [PC_W-1:0]  start_q, end_q, pc_mid;
  logic [CNT_W-1:0] cnt_q, cnt_dec;
  rpt_act_e         act;

  rpt_regs #(.PC_W(PC_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_start(cfg_start),
    .cfg_end(cfg_end), .cfg_count(cfg_count), .word_done(word_done),
    .act(act), .cnt_dec(cnt_dec), .start_q(start_q), .end_q(end_q),
    .cnt_q(cnt_q), .active_q(rpt_active)
  );

  rpt_match #(.PC_W(PC_W), .CNT_W(CNT_W)) u_match (
    .active_q(rpt_active), .start_q(start_q), .end_q(end_q), .cnt_q(cnt_q),
    .pc_after(pc_after), .act(act), .cnt_dec(cnt_dec), .pc_mid(pc_mid)
  );

  pc_step #(.PC_W(PC_W)) u_step (
    .clk(clk), .rst(rst), .reset_vec(reset_vec), .word_done(word_done),
    .pc_before(pc_before), .pc_mid(pc_mid), .next_pc(next_pc)
  );
endmodule

// File: rtl/rpt_pc_ctrl_chk.sv
module rpt_pc_ctrl_chk #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [PC_W-1:0]  reset_vec,
  input logic             cfg_load,
  input logic [CNT_W-1:0] cfg_count,
  input logic             word_done,
  input logic [PC_W-1:0]  pc_before,
  input logic [PC_W-1:0]  pc_after,
  input logic [PC_W-1:0]  next_pc,
  input logic             rpt_active,
  input logic [PC_W-1:0]  start_q,
  input logic [PC_W-1:0]  end_q,
  input logic [CNT_W-1:0] cnt_q
);
  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (next_pc == $past(reset_vec)) && !rpt_active); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(word_done)) |-> $stable(next_pc)); // R2

  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_load)) |-> (rpt_active == ($past(cfg_count) != '0))); // R3

  AST_ARM_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(rpt_active) |-> $past(cfg_load)); // R3

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(word_done) && !$past(rpt_active) && ($past(pc_after) != $past(pc_before)))
    |-> (next_pc == $past(pc_after))); // R8

  AST_STEP_WORD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(word_done) && !$past(rpt_active) && ($past(pc_after) == $past(pc_before)))
    |-> (next_pc == $past(pc_before) + PC_W'(1))); // R5

  AST_LOOP_BACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(word_done) && !$past(cfg_load) && $past(rpt_active) &&
     ($past(pc_after) == $past(end_q)) && ($past(cnt_q) > CNT_W'(1)) &&
     ($past(start_q) != $past(pc_before)))
    |-> (next_pc == $past(start_q)) && rpt_active); // R6

  AST_LAST_EXIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(word_done) && !$past(cfg_load) && $past(rpt_active) &&
     ($past(pc_after) == $past(end_q)) && ($past(cnt_q) == CNT_W'(1)))
    |-> !rpt_active && (cnt_q == '0)); // R7
endmodule

bind rpt_pc_ctrl rpt_pc_ctrl_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reset_vec(reset_vec), .cfg_load(cfg_load),
  .cfg_count(cfg_count), .word_done(word_done), .pc_before(pc_before),
  .pc_after(pc_after), .next_pc(next_pc), .rpt_active(rpt_active),
  .start_q(start_q), .end_q(end_q), .cnt_q(cnt_q)
);

// File: tb/sim_rpt_pc_ctrl.sv
module sim_rpt_pc_ctrl;
  localparam int PC_W = 16;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic        ld;
    logic [15:0] st, en, cn, pb, pa, exp_pc;
    logic        exp_act;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h10, 16'h13, 16'd3, 16'h10, 16'h10, 16'h11, 1'b1}, // R3 R5
    '{1'b0, 16'h0,  16'h0,  16'd0, 16'h11, 16'h11, 16'h12, 1'b1}, // R5
    '{1'b0, 16'h0,  16'h0,  16'd0, 16'h13, 16'h13, 16'h10, 1'b1}, // R6
    '{1'b0, 16'h0,  16'h0,  16'd0, 16'h13, 16'h13, 16'h10, 1'b1}, // R6
    '{1'b0, 16'h0,  16'h0,  16'd0, 16'h13, 16'h13, 16'h14, 1'b0}, // R7
    '{1'b0, 16'h0,  16'h0,  16'd0, 16'h13, 16'h13, 16'h14, 1'b0}, // R8
    '{1'b0, 16'h0,  16'h0,  16'd0, 16'h20, 16'h40, 16'h40, 1'b0}, // R4
    '{1'b1, 16'h50, 16'h60, 16'd2, 16'h55, 16'h60, 16'h50, 1'b1}, // R6
    '{1'b0, 16'h0,  16'h0,  16'd0, 16'h60, 16'h30, 16'h30, 1'b1}, // R4
    '{1'b0, 16'h0,  16'h0,  16'd0, 16'h5F, 16'h60, 16'h60, 1'b0}, // R7
    '{1'b1, 16'h70, 16'h71, 16'd0, 16'h71, 16'h71, 16'h72, 1'b0}  // R3 R8
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] reset_vec = 16'h0100;
  logic cfg_load = 1'b0;
  logic [PC_W-1:0] cfg_start = '0, cfg_end = '0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic word_done = 1'b0;
  logic [PC_W-1:0] pc_before = '0, pc_after = '0;
  logic [PC_W-1:0] next_pc;
  logic rpt_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rpt_pc_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .reset_vec(reset_vec), .cfg_load(cfg_load),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_count(cfg_count),
    .word_done(word_done), .pc_before(pc_before), .pc_after(pc_after),
    .next_pc(next_pc), .rpt_active(rpt_active)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge
  task automatic load(logic [15:0] s, logic [15:0] e, logic [15:0] c);
    cfg_load = 1'b1; cfg_start = s; cfg_end = e; cfg_count = c;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic word(logic [15:0] pb, logic [15:0] pa);
    word_done = 1'b1; pc_before = pb; pc_after = pa;
    @(negedge clk);
    word_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 next_pc", next_pc, 16'h0100);
    check("R1 active", {15'b0, rpt_active}, 16'h0);

    foreach (VEC[i]) begin
      if (VEC[i].ld) load(VEC[i].st, VEC[i].en, VEC[i].cn);
      word(VEC[i].pb, VEC[i].pa);
      check($sformatf("vec%0d next_pc", i), next_pc, VEC[i].exp_pc);
      check($sformatf("vec%0d active", i), {15'b0, rpt_active}, {15'b0, VEC[i].exp_act});
    end

    // R2: no word strobe, inputs wander, next_pc holds
    pc_before = 16'h1234; pc_after = 16'h4321;
    repeat (3) @(negedge clk);
    check("R2 hold", next_pc, 16'h72);

    // R5: wrap at the top of the address space
    word(16'hFFFF, 16'hFFFF);
    check("R5 wrap", next_pc, 16'h0000);

    // R6: one-word loop where start equals pc_before steps by one
    load(16'h30, 16'h30, 16'd3);
    word(16'h30, 16'h30);
    check("R6 start==pc_before", next_pc, 16'h31);
    check("R6 still active", {15'b0, rpt_active}, 16'h1);

    // R9: load and word together, word uses the old state
    load(16'h10, 16'h13, 16'd1);
    cfg_load = 1'b1; cfg_start = 16'hA0; cfg_end = 16'hB0; cfg_count = 16'd5;
    word(16'h13, 16'h13);
    cfg_load = 1'b0;
    check("R9 old state exit", next_pc, 16'h14);
    check("R9 new state armed", {15'b0, rpt_active}, 16'h1);
    word(16'hB0, 16'hB0);
    check("R9 new loop back", next_pc, 16'hA0);

    // R1: reset in mid-loop
    reset_vec = 16'h0200;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid reset pc", next_pc, 16'h0200);
    check("R1 mid reset active", {15'b0, rpt_active}, 16'h0);
    word(16'hB0, 16'hB0);
    check("R1 loop forgotten", next_pc, 16'hB1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule